// File: doc/BRIEF.md
# Faultable Split-Write Bus Sequencer

This block takes operand writes of byte, word or long size from the execution core and puts them on a 16-bit external data path. A long operand goes out as two word accesses: the upper word first at the base address, then the lower word at base + 2. Each access is a request/acknowledge handshake. A separate bus-error input can end an access in place of the acknowledge.

When an access ends in a bus error, the block freezes a fault status record and pulses a strobe for one clock. The record holds the address of the failed access, the part of the operand still left to transfer, a flag that is set when the failure hit the second half of a long, the direction, the function code, and a rerun-request flag. Fault handling later writes an edited record and the 32-bit data buffer back through a restore port. If the rerun flag in that record is set, the block replays the pending cycle using the restored fields. Software can replay a whole long by restoring the address minus two with the long size code. A restored read is carried out on the bus, and whatever the bus returns is dropped.

Top module: `splitWriteSeq`

## Requirements
- R1: Size codes are 01 = byte, 10 = word, 00 = long. A byte or word request makes exactly one access. A byte drives its value on both halves of `busData`. It raises `laneHi` when address bit 0 is 0 and `laneLo` when address bit 0 is 1. A word drives data bits 15:0 with both lanes raised.
- R2: A long request makes two accesses. The first carries data bits 31:16 at the base address with size 00. The second carries bits 15:0 at base + 2 with size 10.
- R3: `busy` is high from the clock after a request is accepted until one clock after the final acknowledge. Requests presented while `busy` is high are ignored.
- R4: A word or long request with address bit 0 set starts no access. It raises `misalignErr` for exactly one clock, in the cycle after the request. Byte requests at any address are never flagged.
- R5: A bus error ends the access. In the next cycle `faultStrobe` is high for one clock, and the record holds the failing address, the direction (`fltRw`, 1 = read), the function code, and `fltRerun` = 1.
- R6: The recorded size is what remains to be transferred. A fault on the first half of a long records 00 with `fltLong` = 0. A fault on the second half records 10 with `fltLong` = 1 and the address base + 2.
- R7: A restore with the rerun flag set reruns the cycle with the restored address, size, direction, function code and data buffer. A restored word drives data buffer bits 15:0.
- R8: A restored record with direction = read performs a read access (`busRw` = 1) with the restored function code. It completes without a fault strobe and leaves the fault record unchanged.
- R9: A restore with size 00 and an adjusted address reissues both halves of the long, starting at the restored address.
- R10: A restore with the rerun flag clear starts no access and leaves `busy` low.
- R11: While an access waits for its acknowledge, `busAddr`, `busData`, `busSize` and the lane selects hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Write request |
| reqAddr | input | ADDR_W | Write address |
| reqSize | input | 2 | Write size code |
| reqFc | input | FC_W | Write function code |
| reqData | input | 32 | Write operand, byte/word right-aligned |
| busy | output | 1 | Sequence in progress |
| misalignErr | output | 1 | One-clock pulse for a rejected misaligned request |
| rstoValid | input | 1 | Restore strobe (has priority over reqValid) |
| rstoAddr | input | ADDR_W | Restored fault address |
| rstoSize | input | 2 | Restored remaining size |
| rstoLong | input | 1 | Restored second-half flag |
| rstoRw | input | 1 | Restored direction, 1 = read |
| rstoFc | input | FC_W | Restored function code |
| rstoRerun | input | 1 | Restored rerun-request flag |
| rstoData | input | 32 | Restored data buffer |
| busReq | output | 1 | Access request |
| busAddr | output | ADDR_W | Access address |
| busSize | output | 2 | Size code of the current access |
| busRw | output | 1 | Direction, 1 = read |
| busFc | output | FC_W | Function code |
| busData | output | 16 | Write data |
| laneHi | output | 1 | Upper byte lane select |
| laneLo | output | 1 | Lower byte lane select |
| busAck | input | 1 | Access completed |
| busErr | input | 1 | Access ended with bus error |
| faultStrobe | output | 1 | One-clock pulse, fault record valid |
| fltAddr | output | ADDR_W | Fault address |
| fltSize | output | 2 | Remaining size at fault |
| fltLong | output | 1 | Fault on second half of a long |
| fltRw | output | 1 | Fault direction |
| fltFc | output | FC_W | Fault function code |
| fltRerun | output | 1 | Rerun-request flag |

## Verification
On every cycle the assertions check several things. The second half of a long follows its acknowledged first half at base + 2 with size word. Bus outputs stay steady while an access is stalled. A fault strobe follows only an errored access and reports that access's address and size. Misaligned rejections never start a cycle, and no word or long access is ever driven at an odd address. Only the bench's scenarios can show the rest: the lane and data mapping across swept byte addresses, the treatment of a second request while busy, the rerun of edited records, and the silence of a restore whose rerun flag is clear.

// File: rtl/swsPkg.sv
package swsPkg;
  localparam int BUS_W = 16;
  localparam int OP_W  = 2 * BUS_W;

  localparam logic [1:0] SZ_LONG = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef struct packed {
    logic loadReq;
    logic loadRst;
    logic advance;
    logic captureFault;
  } ctlStrobeT;

  function automatic logic isMisaligned(input logic [1:0] sz, input logic a0);
    return (sz != SZ_BYTE) && a0;
  endfunction
endpackage

// File: rtl/swsDatapath.sv
module swsDatapath
  import swsPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int FC_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [FC_W-1:0]   reqFc,
  input  logic [OP_W-1:0]   reqData,
  input  logic [ADDR_W-1:0] rstoAddr,
  input  logic [1:0]        rstoSize,
  input  logic              rstoLong,
  input  logic              rstoRw,
  input  logic [FC_W-1:0]   rstoFc,
  input  logic [OP_W-1:0]   rstoData,
  output logic              lastAccess,
  output logic              reqMis,
  output logic              rstoMis,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic              busRw,
  output logic [FC_W-1:0]   busFc,
  output logic [BUS_W-1:0]  busData,
  output logic              laneHi,
  output logic              laneLo,
  output logic              faultStrobe,
  output logic [ADDR_W-1:0] fltAddr,
  output logic [1:0]        fltSize,
  output logic              fltLong,
  output logic              fltRw,
  output logic [FC_W-1:0]   fltFc,
  output logic              fltRerun
);
  localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(BUS_W / 8);

  logic [ADDR_W-1:0] curAddr;
  logic [1:0]        curSize;
  logic              curRw;
  logic [FC_W-1:0]   curFc;
  logic [OP_W-1:0]   dataBuf;
  logic              curSecond;

  // Access register: loaded from a request or a restore, stepped between halves
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      curSize   <= SZ_BYTE;
      curRw     <= 1'b0;
      curFc     <= '0;
      dataBuf   <= '0;
      curSecond <= 1'b0;
    end else if (ctl.loadReq) begin
      curAddr   <= reqAddr;
      curSize   <= reqSize;
      curRw     <= 1'b0;
      curFc     <= reqFc;
      dataBuf   <= reqData;
      curSecond <= 1'b0;
    end else if (ctl.loadRst) begin
      curAddr   <= rstoAddr;
      curSize   <= rstoSize;
      curRw     <= rstoRw;
      curFc     <= rstoFc;
      dataBuf   <= rstoData;
      curSecond <= rstoLong;
    end else if (ctl.advance) begin
      curAddr   <= curAddr + HALF_STEP;
      curSize   <= SZ_WORD;
      curSecond <= 1'b1;
    end
  end

  // Fault record: frozen on a bus error, strobe registered with it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultStrobe <= 1'b0;
      fltAddr     <= '0;
      fltSize     <= SZ_BYTE;
      fltLong     <= 1'b0;
      fltRw       <= 1'b0;
      fltFc       <= '0;
      fltRerun    <= 1'b0;
    end else begin
      faultStrobe <= ctl.captureFault;
      if (ctl.captureFault) begin
        fltAddr  <= curAddr;
        fltSize  <= curSize;
        fltLong  <= curSecond;
        fltRw    <= curRw;
        fltFc    <= curFc;
        fltRerun <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (curSize)
      SZ_LONG: busData = dataBuf[OP_W-1:BUS_W];
      SZ_BYTE: busData = {2{dataBuf[7:0]}};
      default: busData = dataBuf[BUS_W-1:0];
    endcase
    laneHi = (curSize == SZ_BYTE) ? ~curAddr[0] : 1'b1;
    laneLo = (curSize == SZ_BYTE) ?  curAddr[0] : 1'b1;
  end

  assign lastAccess = (curSize != SZ_LONG);
  assign reqMis     = isMisaligned(reqSize, reqAddr[0]);
  assign rstoMis    = isMisaligned(rstoSize, rstoAddr[0]);
  assign busAddr    = curAddr;
  assign busSize    = curSize;
  assign busRw      = curRw;
  assign busFc      = curFc;
endmodule

// File: rtl/swsControl.sv
module swsControl
  import swsPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqMis,
  input  logic      rstoValid,
  input  logic      rstoRerun,
  input  logic      rstoMis,
  input  logic      busAck,
  input  logic      busErr,
  input  logic      lastAccess,
  output ctlStrobeT ctl,
  output logic      busReq,
  output logic      busy,
  output logic      misalignErr
);
  typedef enum logic {ST_IDLE, ST_ACCESS} seqStateT;

  seqStateT state, stateNext;
  logic     idle;
  logic     rejectNow;

  assign idle = (state == ST_IDLE);

  always_comb begin
    ctl       = '0;
    stateNext = state;
    rejectNow = 1'b0;
    if (idle) begin
      if (rstoValid) begin
        // restore owns the slot; only the rerun flag decides on a cycle
        if (rstoRerun) begin
          if (rstoMis) begin
            rejectNow = 1'b1;
          end else begin
            ctl.loadRst = 1'b1;
            stateNext   = ST_ACCESS;
          end
        end
      end else if (reqValid) begin
        if (reqMis) begin
          rejectNow = 1'b1;
        end else begin
          ctl.loadReq = 1'b1;
          stateNext   = ST_ACCESS;
        end
      end
    end else begin
      if (busErr) begin
        ctl.captureFault = 1'b1;
        stateNext        = ST_IDLE;
      end else if (busAck) begin
        if (lastAccess) begin
          stateNext = ST_IDLE;
        end else begin
          ctl.advance = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      misalignErr <= 1'b0;
    end else begin
      state       <= stateNext;
      misalignErr <= rejectNow;
    end
  end

  assign busReq = ~idle;
  assign busy   = ~idle;
endmodule

// File: rtl/splitWriteSeq.sv
module splitWriteSeq
  import swsPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int FC_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [FC_W-1:0]   reqFc,
  input  logic [31:0]       reqData,
  output logic              busy,
  output logic              misalignErr,
  input  logic              rstoValid,
  input  logic [ADDR_W-1:0] rstoAddr,
  input  logic [1:0]        rstoSize,
  input  logic              rstoLong,
  input  logic              rstoRw,
  input  logic [FC_W-1:0]   rstoFc,
  input  logic              rstoRerun,
  input  logic [31:0]       rstoData,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic              busRw,
  output logic [FC_W-1:0]   busFc,
  output logic [15:0]       busData,
  output logic              laneHi,
  output logic              laneLo,
  input  logic              busAck,
  input  logic              busErr,
  output logic              faultStrobe,
  output logic [ADDR_W-1:0] fltAddr,
  output logic [1:0]        fltSize,
  output logic              fltLong,
  output logic              fltRw,
  output logic [FC_W-1:0]   fltFc,
  output logic              fltRerun
);
  ctlStrobeT ctl;
  logic      lastAccess;
  logic      reqMis;
  logic      rstoMis;

  swsControl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqMis     (reqMis),
    .rstoValid  (rstoValid),
    .rstoRerun  (rstoRerun),
    .rstoMis    (rstoMis),
    .busAck     (busAck),
    .busErr     (busErr),
    .lastAccess (lastAccess),
    .ctl        (ctl),
    .busReq     (busReq),
    .busy       (busy),
    .misalignErr(misalignErr)
  );

  swsDatapath #(.ADDR_W(ADDR_W), .FC_W(FC_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .reqFc      (reqFc),
    .reqData    (reqData),
    .rstoAddr   (rstoAddr),
    .rstoSize   (rstoSize),
    .rstoLong   (rstoLong),
    .rstoRw     (rstoRw),
    .rstoFc     (rstoFc),
    .rstoData   (rstoData),
    .lastAccess (lastAccess),
    .reqMis     (reqMis),
    .rstoMis    (rstoMis),
    .busAddr    (busAddr),
    .busSize    (busSize),
    .busRw      (busRw),
    .busFc      (busFc),
    .busData    (busData),
    .laneHi     (laneHi),
    .laneLo     (laneLo),
    .faultStrobe(faultStrobe),
    .fltAddr    (fltAddr),
    .fltSize    (fltSize),
    .fltLong    (fltLong),
    .fltRw      (fltRw),
    .fltFc      (fltFc),
    .fltRerun   (fltRerun)
  );
endmodule

// File: rtl/swsChecker.sv
module swsChecker #(
  parameter int ADDR_W = 24,
  parameter int FC_W   = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              misalignErr,
  input logic              busReq,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        busSize,
  input logic [15:0]       busData,
  input logic              laneHi,
  input logic              laneLo,
  input logic              busAck,
  input logic              busErr,
  input logic              faultStrobe,
  input logic [ADDR_W-1:0] fltAddr,
  input logic [1:0]        fltSize
);
  // R2: second half follows an acknowledged first half
  assert_long_second_half_R2: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck && !busErr && busSize == 2'b00
      |=> busReq && busSize == 2'b10 && busAddr == $past(busAddr) + ADDR_W'(2));

  // R3: busy drops the clock after the final acknowledge
  assert_busy_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck && !busErr && busSize != 2'b00 |=> !busy);

  // R4: a rejected request never starts a cycle; no odd word/long access
  assert_misalign_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    misalignErr |-> !busReq);
  assert_aligned_access_R4: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busSize != 2'b01 |-> !busAddr[0]);

  // R5: strobe follows only an errored access, for one clock
  assert_fault_origin_R5: assert property (@(posedge clk) disable iff (!rstN)
    faultStrobe |-> $past(busReq && busErr));
  assert_fault_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    faultStrobe |=> !faultStrobe);

  // R6: record carries the failing access's address and remaining size
  assert_fault_record_R6: assert property (@(posedge clk) disable iff (!rstN)
    faultStrobe |-> fltAddr == $past(busAddr) && fltSize == $past(busSize));

  // R11: bus outputs steady while waiting
  assert_stall_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck && !busErr
      |=> busReq && $stable(busAddr) && $stable(busData) && $stable(busSize)
          && $stable(laneHi) && $stable(laneLo));
endmodule

bind splitWriteSeq swsChecker #(.ADDR_W(ADDR_W), .FC_W(FC_W)) u_chk (.*);

// File: tb/splitWriteSeq_tb.sv
module splitWriteSeq_tb;
  localparam int AW = 24;
  localparam int FW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0]    reqSize = 2'b01;
  logic [FW-1:0] reqFc = '0;
  logic [31:0]   reqData = '0;
  logic          busy, misalignErr;
  logic          rstoValid = 1'b0;
  logic [AW-1:0] rstoAddr = '0;
  logic [1:0]    rstoSize = 2'b01;
  logic          rstoLong = 1'b0, rstoRw = 1'b0, rstoRerun = 1'b0;
  logic [FW-1:0] rstoFc = '0;
  logic [31:0]   rstoData = '0;
  logic          busReq, busRw, laneHi, laneLo;
  logic [AW-1:0] busAddr;
  logic [1:0]    busSize;
  logic [FW-1:0] busFc;
  logic [15:0]   busData;
  logic          busAck = 1'b0, busErr = 1'b0;
  logic          faultStrobe, fltLong, fltRw, fltRerun;
  logic [AW-1:0] fltAddr;
  logic [1:0]    fltSize;
  logic [FW-1:0] fltFc;

  splitWriteSeq #(.ADDR_W(AW), .FC_W(FW)) u_dut (.*);

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  logic [AW-1:0] logAddr [0:3];
  logic [15:0]   logData [0:3];
  logic [1:0]    logSize [0:3];
  logic          logHi [0:3];
  logic          logLo [0:3];
  logic          logRw [0:3];
  logic [FW-1:0] logFc [0:3];
  int            nSeen;

  // respond to up to expN accesses; errAt = index to answer with bus error
  task automatic serve(input int expN, input int errAt, input int delay);
    nSeen = 0;
    for (int i = 0; i < expN; i++) begin
      int t = 0;
      while (!busReq && t < 20) begin
        @(negedge clk);
        t++;
      end
      if (!busReq) return;
      logAddr[i] = busAddr; logData[i] = busData; logSize[i] = busSize;
      logHi[i] = laneHi; logLo[i] = laneLo; logRw[i] = busRw; logFc[i] = busFc;
      nSeen++;
      for (int d = 0; d < delay; d++) begin
        @(negedge clk);
        chk("R11 stall addr", busAddr, logAddr[i]);
        chk("R11 stall data", busData, logData[i]);
      end
      if (i == errAt) busErr = 1'b1; else busAck = 1'b1;
      @(negedge clk);
      busAck = 1'b0;
      busErr = 1'b0;
      if (i == errAt) return;
    end
  endtask

  task automatic issueReq(input logic [AW-1:0] a, input logic [1:0] s,
                          input logic [31:0] d, input logic [FW-1:0] f);
    reqValid = 1'b1; reqAddr = a; reqSize = s; reqData = d; reqFc = f;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic issueRst(input logic [AW-1:0] a, input logic [1:0] s, input logic lg,
                          input logic rw, input logic [FW-1:0] f, input logic rr,
                          input logic [31:0] d);
    rstoValid = 1'b1; rstoAddr = a; rstoSize = s; rstoLong = lg; rstoRw = rw;
    rstoFc = f; rstoRerun = rr; rstoData = d;
    @(negedge clk);
    rstoValid = 1'b0;
  endtask

  initial begin
    logic [AW-1:0] base;
    logic [31:0]   dat;
    repeat (3) @(negedge clk);
    // reset state
    chk("R3 reset busy", busy, 0);
    chk("R3 reset busReq", busReq, 0);
    chk("R5 reset strobe", faultStrobe, 0);
    chk("R4 reset misalign", misalignErr, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: byte sweep over 8 addresses
    for (int a = 0; a < 8; a++) begin
      logic [7:0] b = 8'h11 * (a + 1) ^ 8'h5a;
      issueReq(AW'(24'h000100 + a), 2'b01, {24'habcdef, b}, 3'd1);
      chk("R3 busy during byte", busy, 1);
      serve(1, -1, 0);
      chk("R1 byte count", nSeen, 1);
      chk("R1 byte addr", logAddr[0], 24'h000100 + a);
      chk("R1 byte data", logData[0], {b, b});
      chk("R1 byte laneHi", logHi[0], (a % 2) == 0);
      chk("R1 byte laneLo", logLo[0], (a % 2) == 1);
      chk("R1 byte size", logSize[0], 2'b01);
      chk("R3 busy released", busy, 0);
      repeat (2) @(negedge clk);
      chk("R1 byte no extra access", busReq, 0);
    end

    // R1: words at even addresses
    for (int a = 0; a < 4; a++) begin
      dat = 32'h1234_0000 | (32'h0f0f * (a + 3));
      issueReq(AW'(24'h002000 + 2 * a), 2'b10, dat, 3'd2);
      serve(1, -1, 0);
      chk("R1 word count", nSeen, 1);
      chk("R1 word data", logData[0], dat[15:0]);
      chk("R1 word lanes", {logHi[0], logLo[0]}, 2'b11);
      chk("R1 word fc", logFc[0], 3'd2);
      chk("R3 word busy released", busy, 0);
    end

    // R2: longs
    for (int a = 0; a < 4; a++) begin
      base = AW'(24'h004000 + 8 * a);
      dat  = 32'hc0de_0000 + 32'h1357_2468 * a;
      issueReq(base, 2'b00, dat, 3'd5);
      serve(2, -1, 0);
      chk("R2 long count", nSeen, 2);
      chk("R2 long addr0", logAddr[0], base);
      chk("R2 long addr1", logAddr[1], base + 2);
      chk("R2 long data0", logData[0], dat[31:16]);
      chk("R2 long data1", logData[1], dat[15:0]);
      chk("R2 long size0", logSize[0], 2'b00);
      chk("R2 long size1", logSize[1], 2'b10);
      chk("R3 long busy released", busy, 0);
    end

    // R3 and R11: request while busy ignored, stalled acknowledge
    issueReq(24'h006000, 2'b00, 32'haaaa_5555, 3'd3);
    reqValid = 1'b1; reqAddr = 24'h00700a; reqSize = 2'b10; reqData = 32'h1;
    @(negedge clk);
    reqValid = 1'b0;
    serve(2, -1, 3);
    chk("R3 ignored count", nSeen, 2);
    chk("R3 ignored addr0", logAddr[0], 24'h006000);
    chk("R3 ignored addr1", logAddr[1], 24'h006002);
    repeat (3) @(negedge clk);
    chk("R3 ignored request never ran", busReq, 0);

    // R4: misalignment sweep
    for (int s = 0; s < 3; s++) begin
      for (int lsb = 0; lsb < 2; lsb++) begin
        logic [1:0] sz = (s == 0) ? 2'b01 : (s == 1) ? 2'b10 : 2'b00;
        logic expMis = (sz != 2'b01) && (lsb == 1);
        issueReq(AW'(24'h008010 + lsb), sz, 32'h0102_0304, 3'd4);
        chk("R4 misalign flag", misalignErr, expMis);
        chk("R4 busy", busy, !expMis);
        if (expMis) begin
          @(negedge clk);
          chk("R4 misalign one clock", misalignErr, 0);
          chk("R4 no access", busReq, 0);
        end else begin
          serve((sz == 2'b00) ? 2 : 1, -1, 0);
          chk("R4 aligned ran", nSeen, (sz == 2'b00) ? 2 : 1);
        end
      end
    end

    // R5: fault on a byte
    issueReq(24'h00a003, 2'b01, 32'h77, 3'd6);
    serve(1, 0, 1);
    chk("R5 strobe", faultStrobe, 1);
    chk("R5 flt addr", fltAddr, 24'h00a003);
    chk("R5 flt size", fltSize, 2'b01);
    chk("R5 flt long", fltLong, 0);
    chk("R5 flt rw", fltRw, 0);
    chk("R5 flt fc", fltFc, 3'd6);
    chk("R5 flt rerun", fltRerun, 1);
    chk("R5 busy after fault", busy, 0);
    @(negedge clk);
    chk("R5 strobe one clock", faultStrobe, 0);

    // R6: first-half fault
    issueReq(24'h00b000, 2'b00, 32'hdead_beef, 3'd1);
    serve(2, 0, 0);
    chk("R6 first-half count", nSeen, 1);
    chk("R6 first-half size", fltSize, 2'b00);
    chk("R6 first-half long", fltLong, 0);
    chk("R6 first-half addr", fltAddr, 24'h00b000);

    // R6: second-half fault
    issueReq(24'h00c000, 2'b00, 32'hfeed_f00d, 3'd5);
    serve(2, 1, 0);
    chk("R6 second-half count", nSeen, 2);
    chk("R6 second-half strobe", faultStrobe, 1);
    chk("R6 second-half size", fltSize, 2'b10);
    chk("R6 second-half long", fltLong, 1);
    chk("R6 second-half addr", fltAddr, 24'h00c002);
    @(negedge clk);

    // R7: rerun remaining word
    issueRst(fltAddr, fltSize, fltLong, fltRw, fltFc, 1'b1, 32'hfeed_f00d);
    serve(2, -1, 0);
    chk("R7 rerun count", nSeen, 1);
    chk("R7 rerun addr", logAddr[0], 24'h00c002);
    chk("R7 rerun data", logData[0], 16'hf00d);
    chk("R7 rerun fc", logFc[0], 3'd5);
    chk("R7 rerun rw", logRw[0], 0);
    chk("R7 busy released", busy, 0);

    // R9: rerun whole long from adjusted address
    issueRst(24'h00c000, 2'b00, 1'b1, 1'b0, 3'd5, 1'b1, 32'hfeed_f00d);
    serve(2, -1, 0);
    chk("R9 count", nSeen, 2);
    chk("R9 addr0", logAddr[0], 24'h00c000);
    chk("R9 addr1", logAddr[1], 24'h00c002);
    chk("R9 data0", logData[0], 16'hfeed);
    chk("R9 data1", logData[1], 16'hf00d);

    // R10: rerun flag clear
    issueRst(24'h00d000, 2'b00, 1'b0, 1'b0, 3'd2, 1'b0, 32'h1111_2222);
    chk("R10 busy stays low", busy, 0);
    for (int k = 0; k < 4; k++) begin
      chk("R10 no access", busReq, 0);
      @(negedge clk);
    end

    // R8: restored read
    issueRst(24'h00e004, 2'b10, 1'b0, 1'b1, 3'd7, 1'b1, 32'h3333_4444);
    serve(1, -1, 0);
    chk("R8 read count", nSeen, 1);
    chk("R8 read rw", logRw[0], 1);
    chk("R8 read fc", logFc[0], 3'd7);
    chk("R8 read addr", logAddr[0], 24'h00e004);
    chk("R8 no strobe", faultStrobe, 0);
    chk("R8 record kept", fltAddr, 24'h00c002);
    chk("R8 busy released", busy, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule